// File: doc/BRIEF.md
# Fault-Only-First Segmented Vector Load Unit

This unit carries out one unit-stride segmented vector load in which every memory element has a fixed width of 8, 16, 32 or 64 bits. Each element read from memory is widened to the selected vector element width, either by sign extension or by zero extension. Elements are walked in order from 0 up to the vector length minus one. Within each element the fields are walked from 0 up to the field count minus one. Each active field issues one memory request. Once the response arrives, one register write follows. An element that the mask turns off issues no request, and its fields are all written as zero.

The termination condition is an active field that loads the value zero. When it occurs, that zero is still written and the walk stops immediately. The index of the element that held the zero becomes the new vector length. Writes already made are kept. No request and no write follows the stop.

The unit is driven by a controller state machine with these states:
- `S_IDLE` waits for `start_i` and latches the configuration, then moves to `S_CHECK`.
- `S_CHECK` moves to `S_DONE` when the configuration is illegal or the length is zero. Otherwise it moves to `S_ISSUE` or `S_ZERO`, depending on the mask bit of element 0.
- `S_ISSUE` raises one memory request and moves to `S_WAIT`.
- `S_WAIT` holds until `mem_rvalid_i`. It then writes the widened value. It goes to `S_DONE` on a zero value or on the last field. It goes back to `S_ISSUE` for the next field. After the last field of an element, it goes to `S_ISSUE` or `S_ZERO`, chosen by the next element's mask bit.
- `S_ZERO` writes a zero and then takes the same next-step choices as `S_WAIT`.
- `S_DONE` pulses `done_o` and returns to `S_IDLE`.

Top module: `vec_ff_seg_load`

## Requirements
- R1: The configuration is illegal when `sew_i` < `mem_w_i` (codes 0..3 mean 8, 16, 32 and 64 bits) or when (`nf_m1_i`+1)·2^`lmul_log_i` > 8. An illegal configuration ends with `done_o`=1, `illegal_o`=1 and `new_vl_o`=`vl_i`, with no request and no write.
- R2: The request for element i, field f has `mem_addr_o` = base + (i·(`nf_m1_i`+1) + f)·2^`mem_w_i`, and `mem_size_o` equals `mem_w_i`.
- R3: `wr_data_o` holds the low 2^`mem_w_i` bytes of `mem_rdata_i`, sign-extended when `sgn_i`=1 and zero-extended otherwise. Bits above the selected element width are zero. Response bits above the memory width are ignored.
- R4: A masked-off element (`mask_i` bit i = 0) issues no request, and each of its fields is written with data 0.
- R5: When an active field loads zero, the zero is written, `new_vl_o` becomes that element's index i, and no further request or write occurs.
- R6: Without an early stop, every (i, f) is written in element-major, field-minor order. Each write has `wr_elem_o`=i and `wr_vreg_o`=(`vd_i` + f·2^`lmul_log_i`) mod 32. The run ends with `new_vl_o`=`vl_i`.
- R7: A legal run with `vl_i`=0 ends with `done_o`, no request, no write and `new_vl_o`=0.
- R8: `done_o` is a one-cycle pulse with `vstart_o`=0, `illegal_o` valid and `busy_o` high. `busy_o` is low in the following cycle.
- R9: At most one memory request is outstanding. No new request is issued until `mem_rvalid_i` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load; accepted in idle only |
| base_i | input | ADDR_W | Base byte address |
| mem_w_i | input | 2 | Memory element width code |
| sgn_i | input | 1 | 1 = sign-extend, 0 = zero-extend |
| sew_i | input | 2 | Selected element width code |
| nf_m1_i | input | 3 | Field count minus one |
| lmul_log_i | input | 2 | log2 of the group multiplier |
| vl_i | input | VL_W | Vector length (at most MAX_VL) |
| mask_i | input | MAX_VL | Per-element active mask |
| vd_i | input | 5 | Destination base register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_size_o | output | 2 | Request width code |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read data, element in low bits |
| wr_en_o | output | 1 | Register write strobe |
| wr_vreg_o | output | 5 | Written register number |
| wr_elem_o | output | VL_W | Written element index |
| wr_data_o | output | 64 | Widened element value |
| done_o | output | 1 | End-of-instruction pulse |
| new_vl_o | output | VL_W | Resulting vector length, valid with done |
| vstart_o | output | VL_W | Start index, zero with done |
| illegal_o | output | 1 | Illegal configuration, valid with done |
| busy_o | output | 1 | Instruction in progress |

## Verification
The assertions assume several things about the inputs:
- `vl_i` never exceeds MAX_VL.
- `mem_rvalid_i` comes only in `S_WAIT`, exactly once per request.
- The configuration inputs matter only in the cycle where `start_i` is taken in idle.

The bench holds to these assumptions. Its memory responder answers a request exactly one cycle after seeing it and stays silent otherwise. The bench drives `start_i` only while the unit is idle.

The stimulus sweeps every width and sign combination and every field-count and multiplier pair. It also covers every early-stop position in a small segment. Memory data is generated so that an element is zero only at one chosen address, and the upper response bits are filled with unrelated data.

// File: rtl/vffl_pkg.sv
package vffl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_ISSUE,
        S_WAIT,
        S_ZERO,
        S_DONE
    } ff_state_t;

    localparam int DATA_W = 64;
    localparam int VREG_W = 5;

    // mask selecting the low bytes of a width code (0:8b .. 3:64b)
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] code);
        logic [DATA_W-1:0] m;
        unique case (code)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vffl_legal.sv
module vffl_legal (
    input  logic [1:0] mem_w,
    input  logic [1:0] sew,
    input  logic [2:0] nf_m1,
    input  logic [1:0] lmul_log,
    output logic       illegal
);
    logic [3:0] fields;
    logic [6:0] span;

    always_comb begin
        fields  = {1'b0, nf_m1} + 4'd1;
        span    = {3'b000, fields} << lmul_log;
        illegal = (sew < mem_w) || (span > 7'd8);
    end
endmodule

// File: rtl/vffl_agen.sv
module vffl_agen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        mem_w,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset_q;
    logic [ADDR_W-1:0] stride;

    always_comb begin
        stride = ADDR_W'(1) << mem_w;
        addr   = base + offset_q;
    end

    // running byte offset: segments are contiguous, element-major
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      offset_q <= '0;
        else if (clear)  offset_q <= '0;
        else if (step)   offset_q <= offset_q + stride;
    end
endmodule

// File: rtl/vffl_widen.sv
module vffl_widen
    import vffl_pkg::*;
(
    input  logic [1:0]        mem_w,
    input  logic [1:0]        sew,
    input  logic              sgn,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] value,
    output logic              elem_zero
);
    logic [DATA_W-1:0] cand [4];

    for (genvar g = 0; g < 4; g++) begin : g_width
        localparam int W = 8 << g;
        if (W < DATA_W) begin : g_part
            assign cand[g] = sgn ? {{(DATA_W-W){raw[W-1]}}, raw[W-1:0]}
                                 : {{(DATA_W-W){1'b0}},     raw[W-1:0]};
        end else begin : g_full
            assign cand[g] = raw;
        end
    end

    always_comb begin
        value     = cand[mem_w] & width_mask(sew);
        elem_zero = (raw & width_mask(mem_w)) == '0;
    end
endmodule

// File: rtl/vffl_ctrl.sv
module vffl_ctrl
    import vffl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 64,
    parameter int VL_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        mem_w_i,
    input  logic              sgn_i,
    input  logic [1:0]        sew_i,
    input  logic [2:0]        nf_m1_i,
    input  logic [1:0]        lmul_log_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [4:0]        vd_i,
    input  logic              illegal,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] wide_data,
    input  logic              elem_zero,
    output logic [ADDR_W-1:0] base_q,
    output logic [1:0]        memw_q,
    output logic              sgn_q,
    output logic [1:0]        sew_q,
    output logic [2:0]        nf_q,
    output logic [1:0]        lmul_q,
    output logic              agen_clear,
    output logic              agen_step,
    output logic              mem_req_o,
    output logic              wr_en_o,
    output logic [4:0]        wr_vreg_o,
    output logic [VL_W-1:0]   wr_elem_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o,
    output logic [VL_W-1:0]   new_vl_o,
    output logic [VL_W-1:0]   vstart_o,
    output logic              illegal_o,
    output logic              busy_o
);
    ff_state_t           state, nxt;
    logic [VL_W-1:0]     vl_q, elem_i, nvl_q;
    logic [2:0]          fld;
    logic [MAX_VL-1:0]   mask_sh;
    logic [4:0]          vd_q;
    logic                ill_q;
    logic                fld_last, elem_last, take, step;
    ff_state_t           after_elem;

    always_comb begin
        fld_last   = (fld == nf_q);
        elem_last  = (elem_i + VL_W'(1)) == vl_q;
        take       = (state == S_IDLE) && start_i;
        step       = ((state == S_WAIT) && mem_rvalid_i) || (state == S_ZERO);
        after_elem = mask_sh[1] ? S_ISSUE : S_ZERO;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start_i) nxt = S_CHECK;
            S_CHECK: begin
                if (illegal || (vl_q == '0)) nxt = S_DONE;
                else                         nxt = mask_sh[0] ? S_ISSUE : S_ZERO;
            end
            S_ISSUE: nxt = S_WAIT;
            S_WAIT: begin
                if (mem_rvalid_i) begin
                    if (elem_zero)                  nxt = S_DONE;
                    else if (fld_last && elem_last) nxt = S_DONE;
                    else if (fld_last)              nxt = after_elem;
                    else                            nxt = S_ISSUE;
                end
            end
            S_ZERO: begin
                if (fld_last && elem_last) nxt = S_DONE;
                else if (fld_last)         nxt = after_elem;
                else                       nxt = S_ZERO;
            end
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // configuration latch and walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            memw_q  <= '0;
            sgn_q   <= 1'b0;
            sew_q   <= '0;
            nf_q    <= '0;
            lmul_q  <= '0;
            vl_q    <= '0;
            vd_q    <= '0;
            mask_sh <= '0;
            elem_i  <= '0;
            fld     <= '0;
            nvl_q   <= '0;
            ill_q   <= 1'b0;
        end else if (take) begin
            base_q  <= base_i;
            memw_q  <= mem_w_i;
            sgn_q   <= sgn_i;
            sew_q   <= sew_i;
            nf_q    <= nf_m1_i;
            lmul_q  <= lmul_log_i;
            vl_q    <= vl_i;
            vd_q    <= vd_i;
            mask_sh <= mask_i;
            elem_i  <= '0;
            fld     <= '0;
            nvl_q   <= vl_i;
            ill_q   <= 1'b0;
        end else begin
            if (state == S_CHECK) ill_q <= illegal;
            if ((state == S_WAIT) && mem_rvalid_i && elem_zero) nvl_q <= elem_i;
            if (step) begin
                if (fld_last) begin
                    fld     <= '0;
                    elem_i  <= elem_i + VL_W'(1);
                    mask_sh <= mask_sh >> 1;
                end else begin
                    fld <= fld + 3'd1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        agen_clear = take;
        agen_step  = step;
        mem_req_o  = (state == S_ISSUE);
        wr_en_o    = step;
        wr_vreg_o  = vd_q + 5'({2'b00, fld} << lmul_q);
        wr_elem_o  = elem_i;
        wr_data_o  = (state == S_ZERO) ? '0 : wide_data;
        done_o     = (state == S_DONE);
        new_vl_o   = nvl_q;
        vstart_o   = '0;
        illegal_o  = (state == S_DONE) && ill_q;
        busy_o     = (state != S_IDLE);
    end

    // R1
    illegal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK && illegal) |=> (done_o && illegal_o && !mem_req_o));

    // R5
    zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && mem_rvalid_i && elem_zero) |=> (done_o && new_vl_o == $past(elem_i)));

    // R3
    zext_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && mem_rvalid_i && !sgn_q) |-> ((wr_data_o & ~width_mask(memw_q)) == '0));

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> (!mem_req_o && state == S_WAIT));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R6
    vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o) |-> (new_vl_o <= vl_q));

    // R4
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, wr_en_o, done_o}));
endmodule

// File: rtl/vec_ff_seg_load.sv
module vec_ff_seg_load
    import vffl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 64,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        mem_w_i,
    input  logic              sgn_i,
    input  logic [1:0]        sew_i,
    input  logic [2:0]        nf_m1_i,
    input  logic [1:0]        lmul_log_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [4:0]        vd_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [1:0]        mem_size_o,
    input  logic              mem_rvalid_i,
    input  logic [63:0]       mem_rdata_i,
    output logic              wr_en_o,
    output logic [4:0]        wr_vreg_o,
    output logic [VL_W-1:0]   wr_elem_o,
    output logic [63:0]       wr_data_o,
    output logic              done_o,
    output logic [VL_W-1:0]   new_vl_o,
    output logic [VL_W-1:0]   vstart_o,
    output logic              illegal_o,
    output logic              busy_o
);
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        memw_q, sew_q, lmul_q;
    logic [2:0]        nf_q;
    logic              sgn_q, illegal, agen_clear, agen_step, elem_zero;
    logic [DATA_W-1:0] wide_data;

    vffl_legal u_legal (
        .mem_w    (memw_q),
        .sew      (sew_q),
        .nf_m1    (nf_q),
        .lmul_log (lmul_q),
        .illegal  (illegal)
    );

    vffl_agen #(.ADDR_W(ADDR_W)) u_agen (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (agen_clear),
        .step  (agen_step),
        .base  (base_q),
        .mem_w (memw_q),
        .addr  (mem_addr_o)
    );

    vffl_widen u_widen (
        .mem_w     (memw_q),
        .sew       (sew_q),
        .sgn       (sgn_q),
        .raw       (mem_rdata_i),
        .value     (wide_data),
        .elem_zero (elem_zero)
    );

    vffl_ctrl #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_i),
        .mem_w_i      (mem_w_i),
        .sgn_i        (sgn_i),
        .sew_i        (sew_i),
        .nf_m1_i      (nf_m1_i),
        .lmul_log_i   (lmul_log_i),
        .vl_i         (vl_i),
        .mask_i       (mask_i),
        .vd_i         (vd_i),
        .illegal      (illegal),
        .mem_rvalid_i (mem_rvalid_i),
        .wide_data    (wide_data),
        .elem_zero    (elem_zero),
        .base_q       (base_q),
        .memw_q       (memw_q),
        .sgn_q        (sgn_q),
        .sew_q        (sew_q),
        .nf_q         (nf_q),
        .lmul_q       (lmul_q),
        .agen_clear   (agen_clear),
        .agen_step    (agen_step),
        .mem_req_o    (mem_req_o),
        .wr_en_o      (wr_en_o),
        .wr_vreg_o    (wr_vreg_o),
        .wr_elem_o    (wr_elem_o),
        .wr_data_o    (wr_data_o),
        .done_o       (done_o),
        .new_vl_o     (new_vl_o),
        .vstart_o     (vstart_o),
        .illegal_o    (illegal_o),
        .busy_o       (busy_o)
    );

    assign mem_size_o = memw_q;
endmodule

// File: tb/sim_vec_ff_seg_load.sv
`timescale 1ns/1ps
module sim_vec_ff_seg_load;
    localparam int MAXV = 16;
    localparam int VW   = $clog2(MAXV + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [31:0]     base_i = '0;
    logic [1:0]      mem_w_i = '0, sew_i = '0, lmul_log_i = '0;
    logic            sgn_i = 1'b0;
    logic [2:0]      nf_m1_i = '0;
    logic [VW-1:0]   vl_i = '0;
    logic [MAXV-1:0] mask_i = '0;
    logic [4:0]      vd_i = '0;
    logic            mem_req_o, wr_en_o, done_o, illegal_o, busy_o;
    logic [31:0]     mem_addr_o;
    logic [1:0]      mem_size_o;
    logic            mem_rvalid_i = 1'b0;
    logic [63:0]     mem_rdata_i = '0;
    logic [4:0]      wr_vreg_o;
    logic [VW-1:0]   wr_elem_o, new_vl_o, vstart_o;
    logic [63:0]     wr_data_o;

    vec_ff_seg_load #(.ADDR_W(32), .MAX_VL(MAXV)) u0 (.*);

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit        zon = 0;
    logic [31:0] zaddr = '0;
    logic [1:0]  cur_mw = '0;
    string     cur_req = "";

    // expected transaction lists
    logic [4:0]  e_vreg [256];
    int          e_elem [256];
    logic [63:0] e_data [256];
    logic [31:0] e_addr [256];
    int          e_nw, e_na, e_vl;
    bit          e_ill;
    int          g_nw, g_na;
    bit          done_seen, outst, mon_on;

    function automatic logic [63:0] wm(input int c);
        return (c >= 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << c)) - 64'd1);
    endfunction

    function automatic logic [63:0] memval(input logic [31:0] a);
        logic [63:0] r;
        r = ({32'h0, a} * 64'h9E37_79B9_7F4A_7C15) ^ {a, ~a};
        r = r | 64'd1;
        if (zon && a == zaddr) r = r & ~wm(int'(cur_mw));
        return r;
    endfunction

    function automatic logic [63:0] ext(input logic [63:0] raw, input int mw, input bit sg, input int sw);
        logic [63:0] e;
        int w;
        w = 8 << mw;
        e = raw & wm(mw);
        if (sg && w < 64 && e[w-1]) e = e | ~wm(mw);
        return e & wm(sw);
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    // one-cycle-latency memory responder
    initial begin
        bit pend = 0;
        logic [31:0] pa = '0;
        forever begin
            @(negedge clk);
            if (pend) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = memval(pa);
            end else begin
                mem_rvalid_i = 1'b0;
                mem_rdata_i  = 64'hDEAD_BEEF_0BAD_F00D;
            end
            pend = mem_req_o;
            pa   = mem_addr_o;
        end
    end

    // monitor, sampling well away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (mon_on) begin
                if (mem_rvalid_i) outst = 0;
                if (mem_req_o) begin
                    chk(!outst, "R9 request while outstanding", 64'(outst), 64'd0);
                    outst = 1;
                    if (g_na < e_na) begin
                        chk(mem_addr_o == e_addr[g_na], "R2 address", 64'(mem_addr_o), 64'(e_addr[g_na]));
                        chk(mem_size_o == cur_mw, "R2 size", 64'(mem_size_o), 64'(cur_mw));
                    end else chk(0, "R4 R5 unexpected request", 64'(mem_addr_o), 64'd0);
                    g_na++;
                end
                if (wr_en_o) begin
                    if (g_nw < e_nw) begin
                        chk(wr_data_o == e_data[g_nw], "R3 R4 write data", wr_data_o, e_data[g_nw]);
                        chk(wr_vreg_o == e_vreg[g_nw] && int'(wr_elem_o) == e_elem[g_nw],
                            "R6 write reg/elem", {27'd0, wr_vreg_o, 32'(wr_elem_o)},
                            {27'd0, e_vreg[g_nw], 32'(e_elem[g_nw])});
                    end else chk(0, "R5 unexpected write", 64'(wr_elem_o), 64'd0);
                    g_nw++;
                end
                if (done_o) begin
                    done_seen = 1;
                    chk(int'(new_vl_o) == e_vl, "R5 R6 R7 new length", 64'(new_vl_o), 64'(e_vl));
                    chk(illegal_o == e_ill, "R1 illegal flag", 64'(illegal_o), 64'(e_ill));
                    chk(vstart_o == '0 && busy_o, "R8 vstart/busy at done", {32'(vstart_o), 31'd0, busy_o}, 64'd1);
                    chk(g_nw == e_nw, "R6 write count", 64'(g_nw), 64'(e_nw));
                    chk(g_na == e_na, "R2 request count", 64'(g_na), 64'(e_na));
                end
            end
        end
    end

    task automatic run(input logic [31:0] base, input int mw, input bit sg, input int sw,
                       input int nfm1, input int ll, input int vl, input logic [MAXV-1:0] mask,
                       input int vd, input bit zo, input logic [31:0] za, input string req);
        bit ill, stop;
        int n;
        cur_req = req;
        cur_mw = 2'(mw);
        zon = zo;
        zaddr = za;
        n = nfm1 + 1;
        ill = (sw < mw) || ((n << ll) > 8);
        e_nw = 0; e_na = 0; e_vl = vl; e_ill = ill; stop = 0;
        if (!ill) begin
            for (int i = 0; i < vl && !stop; i++) begin
                for (int f = 0; f < n && !stop; f++) begin
                    logic [31:0] a;
                    logic [63:0] raw;
                    a = base + 32'((i * n + f) << mw);
                    e_vreg[e_nw] = 5'(vd + (f << ll));
                    e_elem[e_nw] = i;
                    if (mask[i]) begin
                        e_addr[e_na] = a; e_na++;
                        raw = memval(a);
                        e_data[e_nw] = ext(raw, mw, sg, sw);
                        if ((raw & wm(mw)) == 64'd0) begin e_vl = i; stop = 1; end
                    end else e_data[e_nw] = 64'd0;
                    e_nw++;
                end
            end
        end
        g_nw = 0; g_na = 0; done_seen = 0; outst = 0;
        @(negedge clk);
        base_i = base; mem_w_i = 2'(mw); sgn_i = sg; sew_i = 2'(sw);
        nf_m1_i = 3'(nfm1); lmul_log_i = 2'(ll); vl_i = VW'(vl); mask_i = mask; vd_i = 5'(vd);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #6;
        chk(busy_o, "R8 busy after start", 64'(busy_o), 64'd1);
        begin
            int cyc = 0;
            while (!done_seen && cyc < 2000) begin @(negedge clk); cyc++; end
            if (!done_seen) chk(0, "watchdog: no done", 64'(cyc), 64'd0);
        end
        @(negedge clk); #6;
        chk(!busy_o && !done_o, "R8 idle after done", {62'd0, busy_o, done_o}, 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "global watchdog", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        mon_on = 0;
        repeat (3) @(negedge clk);
        #6;
        cur_req = "reset R8";
        chk(!busy_o && !done_o && !mem_req_o && !wr_en_o, "reset outputs",
            {60'd0, busy_o, done_o, mem_req_o, wr_en_o}, 64'd0);
        rst_n = 1'b1;
        mon_on = 1;
        // widths and signedness, with masked elements 1 and 3
        for (int mw = 0; mw < 4; mw++)
            for (int sw = mw; sw < 4; sw++)
                for (int sg = 0; sg < 2; sg++)
                    run(32'h1000 + 32'(mw * 256 + sw * 64 + sg * 8), mw, sg[0], sw, 1, 0, 6,
                        16'b0000_0000_0011_0101, 4, 0, 0, "R2 R3 R4 R6");
        // width legality
        for (int mw = 1; mw < 4; mw++)
            for (int sw = 0; sw < mw; sw++)
                run(32'h2000, mw, 1'b0, sw, 0, 0, 3, '1, 0, 0, 0, "R1");
        // field count by group multiplier
        for (int nf = 0; nf < 8; nf++)
            for (int ll = 0; ll < 4; ll++)
                run(32'h3000 + 32'(nf * 16), 1, 1'b1, 1, nf, ll, 2, '1, 3, 0, 0, "R1 R6");
        // early stop at every segment position
        for (int p = 0; p < 12; p++)
            run(32'h4000, 2, 1'b1, 3, 2, 0, 4, '1, 8, 1, 32'h4000 + 32'(p * 4), "R5");
        // a zero at a masked-off element is never loaded
        run(32'h5000, 0, 1'b0, 2, 0, 0, 4, 16'b1101, 1, 1, 32'h5001, "R4 R5");
        // zero length
        run(32'h6000, 1, 1'b0, 2, 2, 1, 0, '1, 0, 0, 0, "R7");
        // full length, back-to-back requests
        run(32'h7000, 3, 1'b1, 3, 0, 0, MAXV, '1, 16, 0, 0, "R6 R9");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule